// File: doc/BRIEF.md
# Floating-point overflow exception detector

This block judges an intermediate floating-point result just before it is written to its destination. For each result it reports whether the value overflows, underflows or is an operand error. The result arrives as a sign, an unbounded signed exponent and a flag that says whether mantissa rounding carried into the exponent. It also comes with a description of where the result goes. A register destination is checked against the selected rounding precision, not against the extended storage format. The single-precision-mantissa multiply and divide operations are the exception: they keep the extended exponent range. A memory destination is checked against its data format. Integer and packed-decimal destinations report an operand error in place of an overflow.

The checks follow a fixed order. Underflow is judged on the exponent as it arrives, before rounding. The rounding carry is then added. Overflow or operand error is judged on that final exponent, and only then is the result handed on. Each flag that is raised is also gathered into a sticky exception byte. That byte keeps its bits until a clear input is pulsed.

Results enter on a valid/ready stream and leave on a valid/ready stream. A result is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`!out_valid || out_ready`). An output held against a low `out_ready` keeps all its fields unchanged.

Top module: `fp_ovf_detect`

## Requirements
- R1: For a register destination (`in_to_mem`=0, `in_sgl_op`=0), the precision code sets the limits: 01 = single (largest final exponent 127), 10 = double (1023), 00 = extended (16383). A final exponent above the limit raises `out_ovf`, even when the value would fit the extended range.
- R2: Precision code 11 on a register destination behaves exactly like extended (00).
- R3: When `in_sgl_op`=1 on a register destination, both the overflow limit (16383) and the underflow limit (-16382) are the extended ones, whatever the precision code.
- R4: For a memory destination, format codes 0 = single, 1 = double and 2 = extended set the limits. The largest final exponents are 127, 1023 and 16383, and the smallest pre-round exponents are -126, -1022 and -16382. `in_sgl_op` and the precision code have no effect.
- R5: Memory format codes 3 = byte, 4 = word, 5 = long and 6/7 = packed never raise `out_ovf` or `out_unf`. They raise `out_operr` when the final exponent is at least 7, 15, 31 or 16384 respectively.
- R6: Underflow is judged on the exponent before the rounding carry is added. For a real-format target, `out_unf` is set when that exponent is below -126, -1022 or -16382 for single, double or extended limits.
- R7: Overflow is judged on the final exponent, which is the input exponent plus the carry flag. For example, single precision with exponent 127 and carry 1 overflows.
- R8: `sticky_exc` holds bit 2 = overflow, bit 1 = underflow and bit 0 = operand error, with the other bits zero. Each accepted result ORs its flags in. `clr_sticky` empties the byte, but a flag from a result accepted in the same cycle stays set.
- R9: Flags and `out_valid` appear on the edge that accepts the input, which is one cycle of latency. `out_valid` and the output fields hold while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R10: After reset, `out_valid`, all flags and `sticky_exc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input result offered |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_sign | input | 1 | Sign of the intermediate result |
| in_exp | input | EXP_W | Signed unbiased exponent before rounding |
| in_carry | input | 1 | Rounding carried into the exponent |
| in_to_mem | input | 1 | 1 = memory destination, 0 = register destination |
| in_prec | input | 2 | Rounding precision for register destinations |
| in_fmt | input | 3 | Memory destination format code |
| in_sgl_op | input | 1 | Single-precision-mantissa multiply/divide |
| out_valid | output | 1 | Output flags valid |
| out_ready | input | 1 | Downstream takes the output |
| out_sign | output | 1 | Sign passed through with the result |
| out_ovf | output | 1 | Overflow |
| out_unf | output | 1 | Underflow |
| out_operr | output | 1 | Operand error (integer or packed out of range) |
| clr_sticky | input | 1 | Clear the sticky exception byte |
| sticky_exc | output | 8 | Sticky exception byte |

## Verification
Every flag of an input accepted at a rising edge is due right after that same edge. That includes its bit in `sticky_exc`. A held output stays due, unchanged, until the edge where `out_ready` is high. A clear acts on the edge where it is sampled. The bench drives its inputs shortly after the falling edge. It advances a behavioural model on each rising edge using the same acceptance rule. It compares `in_ready`, `out_valid`, the flags and the sticky byte at every falling edge, so each result is checked exactly in the cycle it is due.

// File: rtl/fp_ovf_detect_pkg.sv
package fp_ovf_detect_pkg;

  typedef enum logic [1:0] {
    PREC_EXT = 2'b00,
    PREC_SGL = 2'b01,
    PREC_DBL = 2'b10,
    PREC_RSV = 2'b11
  } prec_e;

  typedef enum logic [2:0] {
    FMT_SGL  = 3'd0,
    FMT_DBL  = 3'd1,
    FMT_EXT  = 3'd2,
    FMT_BYTE = 3'd3,
    FMT_WORD = 3'd4,
    FMT_LONG = 3'd5,
    FMT_PKD  = 3'd6,
    FMT_PKD2 = 3'd7
  } fmt_e;

  localparam int EXC_OPERR_BIT = 0;
  localparam int EXC_UNF_BIT   = 1;
  localparam int EXC_OVF_BIT   = 2;

  // bounds applied to one result
  typedef struct packed {
    logic is_int;   // integer or packed target: range error is an operand error
    int   emax;     // largest final exponent that is still in range
    int   emin;     // smallest pre-round exponent that is not an underflow
  } limits_t;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic operr;
  } flags_t;

endpackage

// File: rtl/fp_ovf_limit_sel.sv
module fp_ovf_limit_sel
  import fp_ovf_detect_pkg::*;
#(
  parameter int SGL_EMAX  = 127,
  parameter int DBL_EMAX  = 1023,
  parameter int EXT_EMAX  = 16383,
  parameter int BYTE_W    = 8,
  parameter int WORD_W    = 16,
  parameter int LONG_W    = 32,
  parameter int PKD_LIMIT = 16384
) (
  input  logic       to_mem,
  input  logic [1:0] prec,
  input  logic [2:0] fmt,
  input  logic       sgl_op,
  output limits_t    lim
);
  localparam int SGL_EMIN = 1 - SGL_EMAX;
  localparam int DBL_EMIN = 1 - DBL_EMAX;
  localparam int EXT_EMIN = 1 - EXT_EMAX;
  localparam int BYTE_MAX = BYTE_W - 2;
  localparam int WORD_MAX = WORD_W - 2;
  localparam int LONG_MAX = LONG_W - 2;
  localparam int PKD_MAX  = PKD_LIMIT - 1;

  always_comb begin
    lim.is_int = 1'b0;
    lim.emax   = EXT_EMAX;
    lim.emin   = EXT_EMIN;
    if (!to_mem) begin
      // register target: rounding precision rules, unless mantissa-only op
      if (!sgl_op) begin
        case (prec)
          PREC_SGL: begin lim.emax = SGL_EMAX; lim.emin = SGL_EMIN; end
          PREC_DBL: begin lim.emax = DBL_EMAX; lim.emin = DBL_EMIN; end
          default:  begin lim.emax = EXT_EMAX; lim.emin = EXT_EMIN; end
        endcase
      end
    end else begin
      case (fmt)
        FMT_SGL:  begin lim.emax = SGL_EMAX; lim.emin = SGL_EMIN; end
        FMT_DBL:  begin lim.emax = DBL_EMAX; lim.emin = DBL_EMIN; end
        FMT_EXT:  begin lim.emax = EXT_EMAX; lim.emin = EXT_EMIN; end
        FMT_BYTE: begin lim.is_int = 1'b1; lim.emax = BYTE_MAX; end
        FMT_WORD: begin lim.is_int = 1'b1; lim.emax = WORD_MAX; end
        FMT_LONG: begin lim.is_int = 1'b1; lim.emax = LONG_MAX; end
        default:  begin lim.is_int = 1'b1; lim.emax = PKD_MAX;  end
      endcase
    end
  end

endmodule

// File: rtl/fp_ovf_exp_check.sv
module fp_ovf_exp_check
  import fp_ovf_detect_pkg::*;
#(
  parameter int EXP_W = 18
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic                    carry_i,
  input  limits_t                 lim,
  output flags_t                  flags
);
  localparam int FIN_W = EXP_W + 1;

  logic signed [FIN_W-1:0] fin_exp;
  logic                    range_hi;
  logic                    range_lo;

  always_comb begin
    // step 1: underflow on the exponent before rounding
    range_lo = int'(exp_i) < lim.emin;
    // step 2: apply the rounding carry
    fin_exp  = $signed({exp_i[EXP_W-1], exp_i}) + $signed({{EXP_W{1'b0}}, carry_i});
    // step 3: range check on the final exponent
    range_hi = int'(fin_exp) > lim.emax;

    flags.ovf   = !lim.is_int && range_hi;
    flags.operr =  lim.is_int && range_hi;
    flags.unf   = !lim.is_int && range_lo;
  end

endmodule

// File: rtl/fp_ovf_sticky.sv
module fp_ovf_sticky
  import fp_ovf_detect_pkg::*;
#(
  parameter int EXC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  flags_t           new_flags,
  input  logic             clr,
  output logic [EXC_W-1:0] exc
);
  logic [EXC_W-1:0] add_bits;

  always_comb begin
    add_bits = '0;
    if (take) begin
      add_bits[EXC_OVF_BIT]   = new_flags.ovf;
      add_bits[EXC_UNF_BIT]   = new_flags.unf;
      add_bits[EXC_OPERR_BIT] = new_flags.operr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc <= '0;
    else        exc <= (clr ? '0 : exc) | add_bits;
  end

  // R8: a flag taken in a clearing cycle survives the clear
  p_clr_keeps_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && new_flags.ovf) |=> exc[EXC_OVF_BIT]);

  // R8: without clear or new result the byte is unchanged
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> $stable(exc));

endmodule

// File: rtl/fp_ovf_detect.sv
module fp_ovf_detect
  import fp_ovf_detect_pkg::*;
#(
  parameter int EXP_W    = 18,
  parameter int EXC_W    = 8,
  parameter int SGL_EMAX = 127,
  parameter int DBL_EMAX = 1023,
  parameter int EXT_EMAX = 16383
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic                    in_carry,
  input  logic                    in_to_mem,
  input  logic [1:0]              in_prec,
  input  logic [2:0]              in_fmt,
  input  logic                    in_sgl_op,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_sign,
  output logic                    out_ovf,
  output logic                    out_unf,
  output logic                    out_operr,
  input  logic                    clr_sticky,
  output logic [EXC_W-1:0]        sticky_exc
);
  localparam int EXT_EMIN = 1 - EXT_EMAX;

  limits_t lim;
  flags_t  cur_flags;
  logic    take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  fp_ovf_limit_sel #(
    .SGL_EMAX (SGL_EMAX),
    .DBL_EMAX (DBL_EMAX),
    .EXT_EMAX (EXT_EMAX)
  ) u_lim (
    .to_mem (in_to_mem),
    .prec   (in_prec),
    .fmt    (in_fmt),
    .sgl_op (in_sgl_op),
    .lim    (lim)
  );

  fp_ovf_exp_check #(.EXP_W(EXP_W)) u_chk (
    .exp_i   (in_exp),
    .carry_i (in_carry),
    .lim     (lim),
    .flags   (cur_flags)
  );

  fp_ovf_sticky #(.EXC_W(EXC_W)) u_sticky (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .new_flags (cur_flags),
    .clr       (clr_sticky),
    .exc       (sticky_exc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
      out_operr <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_sign  <= in_sign;
      out_ovf   <= cur_flags.ovf;
      out_unf   <= cur_flags.unf;
      out_operr <= cur_flags.operr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: accepted input is presented on the next cycle
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R9: stalled output keeps every field
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({out_sign, out_ovf, out_unf, out_operr})));

  // R3: mantissa-only ops inside the extended range never flag
  p_sgl_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_to_mem && in_sgl_op &&
     int'(in_exp) < EXT_EMAX && int'(in_exp) >= EXT_EMIN) |=> (!out_ovf && !out_unf));

  // R5: integer and packed targets never report overflow or underflow
  p_int_no_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_to_mem && in_fmt >= 3'd3) |=> (!out_ovf && !out_unf));

  // R8: an overflow reported for a fresh result is also in the sticky byte
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_flags.ovf) |=> (out_ovf && sticky_exc[EXC_OVF_BIT]));

endmodule

// File: tb/fp_ovf_detect_tb.sv
module fp_ovf_detect_tb_top;
  localparam int EXP_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                    in_valid = 0, in_sign = 0, in_carry = 0, in_to_mem = 0, in_sgl_op = 0;
  logic signed [EXP_W-1:0] in_exp = '0;
  logic [1:0]              in_prec = '0;
  logic [2:0]              in_fmt = '0;
  logic                    out_ready = 1'b1, clr_sticky = 1'b0;
  logic                    in_ready, out_valid, out_sign, out_ovf, out_unf, out_operr;
  logic [7:0]              sticky_exc;

  fp_ovf_detect dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_carry(in_carry), .in_to_mem(in_to_mem),
    .in_prec(in_prec), .in_fmt(in_fmt), .in_sgl_op(in_sgl_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
    .out_ovf(out_ovf), .out_unf(out_unf), .out_operr(out_operr),
    .clr_sticky(clr_sticky), .sticky_exc(sticky_exc)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit stall_en = 0;
  bit done     = 0;
  string cur_tag = "R10";

  task automatic chk(string req, string what, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // behavioural reference: returns {ovf, unf, operr}
  function automatic bit [2:0] ref_eval(int e, int c, bit mem, int prec, int fmt, bit sgl);
    int fin, hi, lo;
    bit isint;
    fin = e + c; isint = 0; hi = 16383; lo = -16382;
    if (!mem) begin
      if (!sgl && prec == 1) begin hi = 127;  lo = -126;  end
      if (!sgl && prec == 2) begin hi = 1023; lo = -1022; end
    end else begin
      case (fmt)
        0: begin hi = 127;  lo = -126;  end
        1: begin hi = 1023; lo = -1022; end
        2: ;
        3: begin isint = 1; hi = 6;  end
        4: begin isint = 1; hi = 14; end
        5: begin isint = 1; hi = 30; end
        default: begin isint = 1; hi = 16383; end
      endcase
    end
    if (isint) return {1'b0, 1'b0, fin > hi};
    return {fin > hi, e < lo, 1'b0};
  endfunction

  bit       m_valid = 0, m_sign = 0;
  bit [2:0] m_flags = 0;
  int       m_sticky = 0;
  string    m_tag = "R10";
  bit       m_acc;
  bit [2:0] m_f;
  int       m_nx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 0; m_flags <= 0; m_sticky <= 0; m_sign <= 0;
    end else begin
      m_acc = in_valid && (!m_valid || out_ready);
      m_f   = ref_eval(int'(in_exp), int'(in_carry), in_to_mem, int'(in_prec), int'(in_fmt), in_sgl_op);
      m_nx  = clr_sticky ? 0 : m_sticky;
      if (m_acc) begin
        m_nx = m_nx | (m_f[2] ? 4 : 0) | (m_f[1] ? 2 : 0) | (m_f[0] ? 1 : 0);
        m_valid <= 1; m_flags <= m_f; m_sign <= in_sign; m_tag <= cur_tag;
      end else if (out_ready) m_valid <= 0;
      m_sticky <= m_nx;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R10", "out_valid", int'(out_valid), 0);
      chk("R10", "flags", int'({out_ovf, out_unf, out_operr}), 0);
      chk("R10", "sticky", int'(sticky_exc), 0);
    end else if (!done) begin
      chk("R9", "in_ready", int'(in_ready), int'(!m_valid || out_ready));
      chk("R9", "out_valid", int'(out_valid), int'(m_valid));
      if (m_valid) begin
        chk(m_tag, "ovf", int'(out_ovf), int'(m_flags[2]));
        chk(m_tag, "unf", int'(out_unf), int'(m_flags[1]));
        chk(m_tag, "operr", int'(out_operr), int'(m_flags[0]));
        chk("R9", "sign", int'(out_sign), int'(m_sign));
      end
      chk("R8", "sticky", int'(sticky_exc), m_sticky);
    end
  end

  always @(negedge clk) begin
    #1 out_ready <= stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  task automatic send(string tag, int e, bit c, bit mem, int prec, int fmt, bit sgl, bit clr = 0);
    bit ok;
    @(negedge clk); #2;
    in_valid = 1; in_exp = EXP_W'(e); in_carry = c; in_to_mem = mem;
    in_prec = 2'(prec); in_fmt = 3'(fmt); in_sgl_op = sgl; in_sign = e[0];
    clr_sticky = clr; cur_tag = tag;
    forever begin
      #1 ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk); #2;
    end
    #1 in_valid = 0; clr_sticky = 0;
  endtask

  task automatic clear_only();
    @(negedge clk); #2 clr_sticky = 1;
    @(posedge clk); #1 clr_sticky = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int bases[11] = '{127, 1023, 16383, -126, -1022, -16382, 6, 14, 30, 16384, 0};
    repeat (3) @(posedge clk);
    @(negedge clk); #3 rst_n = 1;
    // R1 register precision limits
    send("R1", 127, 0, 0, 1, 0, 0);
    send("R1", 128, 0, 0, 1, 0, 0);
    send("R1", 200, 0, 0, 1, 0, 0);
    send("R1", 200, 0, 0, 0, 0, 0);
    send("R1", 1023, 0, 0, 2, 0, 0);
    send("R1", 1024, 0, 0, 2, 0, 0);
    send("R1", 16383, 0, 0, 0, 0, 0);
    send("R1", 16384, 0, 0, 0, 0, 0);
    clear_only();
    // R2 reserved precision
    send("R2", 200, 0, 0, 3, 0, 0);
    send("R2", 16384, 0, 0, 3, 0, 0);
    send("R2", -16383, 0, 0, 3, 0, 0);
    // R3 mantissa-only ops
    send("R3", 200, 0, 0, 1, 0, 1);
    send("R3", -200, 0, 0, 2, 0, 1);
    send("R3", 16384, 0, 0, 1, 0, 1);
    // R4 memory real formats
    send("R4", 128, 0, 1, 0, 0, 0);
    send("R4", 1023, 0, 1, 0, 1, 0);
    send("R4", 1024, 0, 1, 0, 1, 0);
    send("R4", 16384, 0, 1, 0, 2, 0);
    send("R4", 200, 0, 1, 0, 0, 1);
    send("R4", -127, 0, 1, 0, 0, 0);
    clear_only();
    // R5 integer and packed
    send("R5", 6, 0, 1, 0, 3, 0);
    send("R5", 7, 0, 1, 0, 3, 0);
    send("R5", 15, 0, 1, 0, 4, 0);
    send("R5", 30, 0, 1, 0, 5, 0);
    send("R5", 30, 1, 1, 0, 5, 0);
    send("R5", 16384, 0, 1, 0, 6, 0);
    send("R5", -20000, 0, 1, 0, 7, 0);
    // R6 underflow before carry, R7 overflow after carry
    send("R6", -127, 1, 0, 1, 0, 0);
    send("R6", -126, 0, 0, 1, 0, 0);
    send("R6", -1023, 0, 0, 2, 0, 0);
    send("R7", 127, 1, 0, 1, 0, 0);
    send("R7", 16383, 1, 0, 0, 0, 0);
    send("R7", 1022, 1, 0, 2, 0, 0);
    // R8 clear versus new flag
    clear_only();
    send("R8", 128, 0, 0, 1, 0, 0);
    clear_only();
    send("R8", -200, 0, 0, 1, 0, 0, 1);
    send("R8", 7, 0, 1, 0, 3, 0, 1);
    // R9 back-pressure with mixed stimulus
    stall_en = 1;
    for (int i = 0; i < 400; i++) begin
      int  e, prec, fmt;
      bit  mem, sgl;
      string t;
      e    = bases[$urandom_range(0, 10)] + int'($urandom_range(0, 4)) - 2;
      if ($urandom_range(0, 1) == 1) e = -e;
      mem  = $urandom_range(0, 1) == 1;
      sgl  = $urandom_range(0, 3) == 0;
      prec = $urandom_range(0, 3);
      fmt  = $urandom_range(0, 7);
      if (mem) t = (fmt >= 3) ? "R5" : "R4";
      else     t = sgl ? "R3" : ((prec == 3) ? "R2" : "R1");
      send(t, e, $urandom_range(0, 1) == 1, mem, prec, fmt, sgl, $urandom_range(0, 9) == 0);
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk);
      end
    end
    stall_en = 0;
    repeat (5) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule